// File: doc/BRIEF.md
# Serial flash command engine

This block sends single commands to serial NOR flash devices over a four-wire serial link (clock, data out, data in, active-low select). Up to four flash devices hang off separate select lines, called banks. Software programs the block through a small 32-bit register bus. It loads the outgoing bytes and picks the bank. It then writes a command word that starts one framed transfer. Completion raises a flag, and can also raise an interrupt.

There are two ways to run a command. In raw mode the engine sends up to four bytes from the transmit register, then clocks in up to four reply bytes. In canned mode a single command word asks for either a flash status read or a write-enable. For a status read, the returned byte lands in the low byte of the status register. For a write-enable, the engine marks that bank as write-enabled. A later status read that finds the device idle turns the mark into a write-complete flag.

The register bus carries no back-pressure: a write is taken in the cycle `bus_wr` is high, and `bus_rdata` is a combinational view of the addressed register. Register offsets are: setup 0x00, command 0x04, status 0x08, transmit 0x0C, receive 0x10.

Top module: `sfe_top`

## Requirements
- R1: After reset, setup (0x00) reads 0x0000_016F: banks enabled [3:0]=0xF, deselect time [7:4]=6, prescaler [15:8]=1, raw-mode bit 28 clear. Command, status, transmit and receive read 0. All selects are high, the serial clock is low and `irq` is low.
- R2: In raw mode (setup bit 28 set), a command write with bit 7 set does two things. It drives the select of the bank in command [13:12] low, and it sends transmit-register bytes lowest byte first, each byte most significant bit first, in clock mode 0. At most one select is low at any time.
- R3: Reply bytes are sampled on rising serial clock edges after the transmit bytes, with data out held low meanwhile. They are packed into the receive register lowest byte first, and the unused upper bytes read 0.
- R4: The serial clock spends max(prescaler,1) system clocks high and the same number low for each bit; a prescaler of 0 behaves as 1.
- R5: After the last bit the select stays high for (deselect+1) serial clock periods. The transfer-finished flag (status bit 8) then reads 1 one system clock later.
- R6: In canned mode (bit 28 clear), command bit 10 sends opcode 0x05 and reads one reply byte into status [7:0]. Bit 10 wins if bit 11 is also set.
- R7: In canned mode, command bit 11 sends opcode 0x06 alone and then sets status bit (12 + bank).
- R8: A canned status read of a bank whose write-mode bit is set, returning bit 0 clear, sets write-complete (status bit 9) and clears that write-mode bit; with bit 0 set neither changes.
- R9: A write to status ANDs bits [15:8] with the written data (so writing zero clears every flag) and leaves bits [7:0] unchanged.
- R10: `irq` is high exactly while (status bit 8 and command bit 8) or (status bit 9 and command bit 9).
- R11: A command aimed at a bank whose enable bit is clear sets status bit 11 and starts no transfer. In raw mode, a command with bit 10 or 11 set sets status bit 10 and starts no transfer.
- R12: A command write arriving while a transfer (including its deselect time) is running is ignored: command readback and the running transfer are unchanged.
- R13: Transmit count [3:0] and receive count [6:4] above 4 are treated as 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Addressed register contents |
| irq | output | 1 | Interrupt request |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 4 | Active-low select, one per bank |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The hardest states to reach are a write-complete event and an ignored command. A write-complete event needs a canned write-enable on a bank, then a canned status read of that bank whose reply shows the device idle. The bench reaches it by following an earlier status read that reported busy with one that reports idle, with the flash model's reply byte chosen for each. For the ignored command, a second command write is issued some cycles into a slow transfer. The bench then confirms that the readback, the select seen and the serial bit stream all belong to the first command.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam logic [4:0] A_SETUP = 5'h00;
  localparam logic [4:0] A_CMD   = 5'h04;
  localparam logic [4:0] A_STAT  = 5'h08;
  localparam logic [4:0] A_TXD   = 5'h0C;
  localparam logic [4:0] A_RXD   = 5'h10;

  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;

  typedef enum logic [1:0] {CMD_NONE, CMD_RAW, CMD_RDSR, CMD_WREN} cmd_e;
  typedef enum logic [1:0] {SH_IDLE, SH_RUN, SH_GAP} sh_state_e;
endpackage

// File: rtl/sfe_tick.sv
module sfe_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] presc,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last;

  assign last = (presc == '0) ? '0 : presc - DIV_W'(1);
  assign tick = en && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!en)      cnt_q <= '0;
    else if (tick)     cnt_q <= '0;
    else               cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/sfe_shift_core.sv
module sfe_shift_core
  import sfe_pkg::*;
#(
  parameter int BYTES  = 4,
  parameter int DSEL_W = 4,
  parameter int CW     = $clog2(BYTES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [BYTES*8-1:0] tx_word,
  input  logic [CW-1:0]      tx_n,
  input  logic [CW-1:0]      rx_n,
  input  logic               tick,
  input  logic [DSEL_W-1:0]  dsel,
  input  logic               miso,
  output logic               busy,
  output logic               cs_act,
  output logic               sclk,
  output logic               mosi,
  output logic [BYTES*8-1:0] rx_word,
  output logic               done
);
  localparam int WB = BYTES * 8;
  localparam int IW = $clog2(WB);
  localparam int BW = $clog2(2 * WB);

  sh_state_e         st_q;
  logic [WB-1:0]     tx_q, rx_q;
  logic [BW:0]       txb_q, tot_q;
  logic [BW-1:0]     bitc_q;
  logic [DSEL_W:0]   gapc_q;
  logic              sclk_q, done_q;
  logic [IW-1:0]     roff, ridx, tidx;

  assign roff = bitc_q[IW-1:0] - txb_q[IW-1:0];
  assign ridx = {roff[IW-1:3], ~roff[2:0]};
  assign tidx = {bitc_q[IW-1:3], ~bitc_q[2:0]};

  assign busy    = (st_q != SH_IDLE);
  assign cs_act  = (st_q == SH_RUN);
  assign sclk    = sclk_q;
  assign rx_word = rx_q;
  assign done    = done_q;
  assign mosi    = cs_act && ({1'b0, bitc_q} < txb_q) && tx_q[tidx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SH_IDLE;
      tx_q   <= '0;
      rx_q   <= '0;
      txb_q  <= '0;
      tot_q  <= '0;
      bitc_q <= '0;
      gapc_q <= '0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        SH_IDLE: if (start) begin
          tx_q   <= tx_word;
          rx_q   <= '0;
          txb_q  <= (BW+1)'(tx_n) << 3;
          tot_q  <= ((BW+1)'(tx_n) + (BW+1)'(rx_n)) << 3;
          bitc_q <= '0;
          gapc_q <= '0;
          sclk_q <= 1'b0;
          st_q   <= ((tx_n == '0) && (rx_n == '0)) ? SH_GAP : SH_RUN;
        end
        SH_RUN: if (tick) begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            if ({1'b0, bitc_q} >= txb_q) rx_q[ridx] <= miso;
          end else begin
            sclk_q <= 1'b0;
            if ({1'b0, bitc_q} == tot_q - (BW+1)'(1)) begin
              st_q   <= SH_GAP;
              gapc_q <= '0;
            end else begin
              bitc_q <= bitc_q + BW'(1);
            end
          end
        end
        SH_GAP: if (tick) begin
          if (gapc_q == {dsel, 1'b1}) begin
            st_q   <= SH_IDLE;
            done_q <= 1'b1;
          end else begin
            gapc_q <= gapc_q + (DSEL_W+1)'(1);
          end
        end
        default: st_q <= SH_IDLE;
      endcase
    end
  end

  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |-> !sclk_q);

  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && sclk_q) |-> $stable(mosi));
endmodule

// File: rtl/sfe_top.sv
module sfe_top
  import sfe_pkg::*;
#(
  parameter int NBANK    = 4,
  parameter int BYTES    = 4,
  parameter int DIV_W    = 8,
  parameter int DSEL_W   = 4,
  parameter int DSEL_DEF = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             irq,
  output logic             spi_sclk,
  output logic [NBANK-1:0] spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam int CW = $clog2(BYTES + 1);
  localparam int KW = $clog2(NBANK);
  localparam int WB = BYTES * 8;
  localparam logic [31:0] RST_SETUP = (32'(1) << 8) | (32'(DSEL_DEF) << 4)
                                    | ((32'(1) << NBANK) - 32'(1));

  logic [31:0]      setup_q, cmd_q, txd_q, rxd_q;
  logic [7:0]       fsr_q;
  logic             tff_q, wcf_q, erf1_q, erf2_q;
  logic [NBANK-1:0] wm_q;
  cmd_e             cur_q, nxt_cmd;
  logic [KW-1:0]    bank_q, bank_w;
  logic             core_busy, core_done, cs_act, tick, start;
  logic [WB-1:0]    rx_word, tx_sel;
  logic [CW-1:0]    txn_sel, rxn_sel;
  logic             wr_cmd, accept, sw_mode, bank_ok;

  function automatic logic [CW-1:0] clamp_n(input logic [3:0] v);
    return (v > 4'(BYTES)) ? CW'(BYTES) : CW'(v);
  endfunction

  assign sw_mode = setup_q[28];
  assign bank_w  = bus_wdata[12 +: KW];
  assign bank_ok = setup_q[bank_w];
  assign wr_cmd  = bus_wr && (bus_addr == A_CMD);
  assign accept  = wr_cmd && !core_busy && !core_done;

  always_comb begin
    nxt_cmd = CMD_NONE;
    if (bank_ok) begin
      if (sw_mode) begin
        if (!bus_wdata[10] && !bus_wdata[11] && bus_wdata[7]) nxt_cmd = CMD_RAW;
      end else if (bus_wdata[10]) nxt_cmd = CMD_RDSR;
      else if (bus_wdata[11])     nxt_cmd = CMD_WREN;
    end
  end

  always_comb begin
    tx_sel  = WB'(OP_WREN);
    txn_sel = CW'(1);
    rxn_sel = '0;
    case (nxt_cmd)
      CMD_RAW: begin
        tx_sel  = txd_q[WB-1:0];
        txn_sel = clamp_n(bus_wdata[3:0]);
        rxn_sel = clamp_n({1'b0, bus_wdata[6:4]});
      end
      CMD_RDSR: begin
        tx_sel  = WB'(OP_RDSR);
        rxn_sel = CW'(1);
      end
      default: ;
    endcase
  end

  assign start = accept && (nxt_cmd != CMD_NONE);

  sfe_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(core_busy),
    .presc(setup_q[8 +: DIV_W]), .tick(tick)
  );

  sfe_shift_core #(.BYTES(BYTES), .DSEL_W(DSEL_W)) u_core (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_sel),
    .tx_n(txn_sel), .rx_n(rxn_sel), .tick(tick),
    .dsel(setup_q[4 +: DSEL_W]), .miso(spi_miso), .busy(core_busy),
    .cs_act(cs_act), .sclk(spi_sclk), .mosi(spi_mosi),
    .rx_word(rx_word), .done(core_done)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_sel
    assign spi_cs_n[b] = !(cs_act && (bank_q == KW'(b)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q <= RST_SETUP;
      cmd_q   <= '0;
      txd_q   <= '0;
      rxd_q   <= '0;
      fsr_q   <= '0;
      tff_q   <= 1'b0;
      wcf_q   <= 1'b0;
      erf1_q  <= 1'b0;
      erf2_q  <= 1'b0;
      wm_q    <= '0;
      cur_q   <= CMD_NONE;
      bank_q  <= '0;
    end else begin
      if (bus_wr && bus_addr == A_SETUP) setup_q <= bus_wdata;
      if (bus_wr && bus_addr == A_TXD)   txd_q   <= bus_wdata;
      if (bus_wr && bus_addr == A_STAT) begin
        tff_q  <= tff_q  & bus_wdata[8];
        wcf_q  <= wcf_q  & bus_wdata[9];
        erf1_q <= erf1_q & bus_wdata[10];
        erf2_q <= erf2_q & bus_wdata[11];
        wm_q   <= wm_q   & bus_wdata[12 +: NBANK];
      end
      if (accept) begin
        cmd_q  <= bus_wdata;
        cur_q  <= nxt_cmd;
        bank_q <= bank_w;
        if (!bank_ok) erf2_q <= 1'b1;
        else if (sw_mode && (bus_wdata[10] || bus_wdata[11])) erf1_q <= 1'b1;
      end
      if (core_done) begin
        tff_q <= 1'b1;
        rxd_q <= 32'(rx_word);
        if (cur_q == CMD_RDSR) begin
          fsr_q <= rx_word[7:0];
          if (wm_q[bank_q] && !rx_word[0]) begin
            wcf_q        <= 1'b1;
            wm_q[bank_q] <= 1'b0;
          end
        end
        if (cur_q == CMD_WREN) wm_q[bank_q] <= 1'b1;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_SETUP: bus_rdata = setup_q;
      A_CMD:   bus_rdata = cmd_q;
      A_STAT:  bus_rdata = 32'({wm_q, erf2_q, erf1_q, wcf_q, tff_q, fsr_q});
      A_TXD:   bus_rdata = txd_q;
      A_RXD:   bus_rdata = rxd_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq = (tff_q && cmd_q[8]) || (wcf_q && cmd_q[9]);

  // R2
  one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n));

  // R5
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |=> tff_q);

  // R12
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && (core_busy || core_done)) |=> $stable(cmd_q));
endmodule

// File: tb/sfe_top_tb_top.sv
`timescale 1ns/1ps
module sfe_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, spi_sclk, spi_mosi, spi_miso;
  logic [3:0]  spi_cs_n;

  int total = 0;
  int bad = 0;
  int nbits = 0;
  int hi_cnt = 0;
  logic [63:0] mlog = '0;
  logic [63:0] cur_reply = '0;
  logic [3:0]  cs_seen = '0;

  always #5 clk = ~clk;

  sfe_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  // flash model: log data out, feed reply frame bit by bit
  always @(posedge spi_sclk) begin
    mlog  = {mlog[62:0], spi_mosi};
    nbits = nbits + 1;
  end
  always @(posedge clk) begin
    cs_seen = cs_seen | ~spi_cs_n;
    if (spi_sclk) hi_cnt = hi_cnt + 1;
  end
  assign spi_miso = (nbits < 64) ? cur_reply[6'(63 - nbits)] : 1'b0;

  typedef struct packed {
    logic [1:0]  bank;
    logic [3:0]  txn;
    logic [2:0]  rxn;
    logic [7:0]  presc;
    logic [31:0] txw;
    logic [63:0] reply;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{2'd0, 4'd1, 3'd3, 8'd1, 32'h0000_009F, 64'h0020_17C2_0000_0000},
    '{2'd3, 4'd4, 3'd0, 8'd2, 32'h5634_12D8, 64'h0},
    '{2'd1, 4'd2, 3'd2, 8'd3, 32'h0000_A50B, 64'h0000_3C81_0000_0000},
    '{2'd2, 4'd7, 3'd5, 8'd0, 32'h0403_0201, 64'h0000_0000_DEAD_BEEF}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic clr_mon();
    nbits = 0; mlog = '0; cs_seen = '0; hi_cnt = 0;
  endtask

  task automatic wait_tff(input string tag);
    logic [31:0] s;
    int n;
    n = 0;
    s = '0;
    while (!s[8] && n < 5000) begin
      rd(5'h08, s);
      n++;
    end
    if (!s[8]) chk({tag, " tff timeout"}, 0, 1);
  endtask

  initial begin
    #1_900_000;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(5'h00, d); chk("R1 setup", d, 32'h0000_016F);
    rd(5'h04, d); chk("R1 cmd", d, 0);
    rd(5'h08, d); chk("R1 status", d, 0);
    rd(5'h10, d); chk("R1 rx", d, 0);
    chk("R1 pins", {spi_cs_n, spi_sclk, irq}, {4'hF, 1'b0, 1'b0});

    // table of raw transfers: R2 R3 R4 R13 R10
    for (int i = 0; i < 4; i++) begin
      vec_t v;
      int tc, rc, pe;
      logic [63:0] e;
      logic [31:0] er;
      v = VEC[i];
      tc = (v.txn > 4) ? 4 : int'(v.txn);
      rc = (v.rxn > 4) ? 4 : int'(v.rxn);
      pe = (v.presc == 0) ? 1 : int'(v.presc);
      e = '0;
      for (int m = 0; m < tc; m++) e = (e << 8) | 64'(v.txw[8*m +: 8]);
      for (int m = 0; m < rc; m++) e = e << 8;
      er = '0;
      for (int j = 0; j < rc; j++) er[8*j +: 8] = v.reply[63-8*(tc+j) -: 8];
      wr(5'h00, (32'd1 << 28) | (32'(v.presc) << 8) | (32'd1 << 4) | 32'hF);
      wr(5'h0C, v.txw);
      cur_reply = v.reply;
      clr_mon();
      wr(5'h04, (32'(v.bank) << 12) | 32'h180 | (32'(v.rxn) << 4) | 32'(v.txn));
      wait_tff("R2");
      chk("R2 R13 bit count", 64'(nbits), 64'(8*(tc+rc)));
      chk("R2 data out", mlog, e);
      chk("R2 select", 64'(cs_seen), 64'(4'b1 << v.bank));
      chk("R4 clock high time", 64'(hi_cnt), 64'(nbits*pe));
      rd(5'h10, d); chk("R3 rx packing", d, er);
      chk("R10 irq on tff", 64'(irq), 1);
      wr(5'h08, 32'h0);
      @(negedge clk);
      chk("R10 irq cleared", 64'(irq), 0);
    end

    // R5 deselect gap: presc 3, dsel 2 -> 2*3*3+1 cycles
    begin
      int cnt;
      wr(5'h00, (32'd1 << 28) | (32'd3 << 8) | (32'd2 << 4) | 32'hF);
      cur_reply = '0;
      clr_mon();
      wr(5'h04, 32'h0000_0081);
      while (spi_cs_n[0]) @(negedge clk);
      while (!spi_cs_n[0]) @(negedge clk);
      bus_addr = 5'h08;
      cnt = 0;
      #1;
      while (!bus_rdata[8] && cnt < 100) begin
        cnt++;
        @(negedge clk);
        #1;
      end
      chk("R5 gap cycles", 64'(cnt), 19);
      wr(5'h08, 32'h0);
    end

    // R7 canned write-enable on bank 2
    wr(5'h00, (32'd1 << 8) | (32'd1 << 4) | 32'hF);
    clr_mon();
    wr(5'h04, (32'd2 << 12) | (32'd1 << 11));
    wait_tff("R7");
    chk("R7 opcode", {mlog[55:0], 8'(nbits)}, {56'h06, 8'd8});
    rd(5'h08, d); chk("R7 write mode bit", d, 32'h0000_4100);
    chk("R10 no irq without enable", 64'(irq), 0);

    // R6 canned status read, device busy
    wr(5'h08, 32'hFFFF_FEFF);
    cur_reply = 64'h0003_0000_0000_0000;
    clr_mon();
    wr(5'h04, (32'd2 << 12) | (32'd1 << 10) | (32'd1 << 11) | (32'd1 << 9));
    wait_tff("R6");
    chk("R6 opcode", {mlog[47:0], 16'(nbits)}, {48'h0500, 16'd16});
    rd(5'h08, d); chk("R6 R8 busy reply", d, 32'h0000_4103);

    // R8 status read, device idle -> write complete
    wr(5'h08, 32'hFFFF_FEFF);
    cur_reply = 64'h0002_0000_0000_0000;
    clr_mon();
    wr(5'h04, (32'd2 << 12) | (32'd1 << 10) | (32'd1 << 9));
    wait_tff("R8");
    rd(5'h08, d); chk("R8 write complete", d, 32'h0000_0302);
    chk("R10 irq on wcf", 64'(irq), 1);

    // R9 partial and full clear
    wr(5'h08, 32'hFFFF_FEFF);
    rd(5'h08, d); chk("R9 partial clear", d, 32'h0000_0202);
    chk("R10 irq held by wcf", 64'(irq), 1);
    wr(5'h08, 32'h0);
    rd(5'h08, d); chk("R9 full clear keeps low byte", d, 32'h0000_0002);
    chk("R10 irq low", 64'(irq), 0);

    // R11 disabled bank, then canned command in raw mode
    wr(5'h00, (32'd1 << 8) | (32'd1 << 4) | 32'hE);
    clr_mon();
    wr(5'h04, (32'd0 << 12) | (32'd1 << 11));
    repeat (20) @(negedge clk);
    rd(5'h08, d); chk("R11 forbidden access", d, 32'h0000_0802);
    chk("R11 no select", 64'(cs_seen), 0);
    wr(5'h08, 32'h0);
    wr(5'h00, (32'd1 << 28) | (32'd1 << 8) | (32'd1 << 4) | 32'hF);
    clr_mon();
    wr(5'h04, (32'd1 << 12) | (32'd1 << 10) | 32'h80);
    repeat (20) @(negedge clk);
    rd(5'h08, d); chk("R11 forbidden write", d, 32'h0000_0402);
    chk("R11 no transfer", 64'(cs_seen), 0);
    wr(5'h08, 32'h0);

    // R12 command write during a running transfer
    wr(5'h00, (32'd1 << 28) | (32'd4 << 8) | (32'd1 << 4) | 32'hF);
    wr(5'h0C, 32'hCAFE_F00D);
    cur_reply = '0;
    clr_mon();
    wr(5'h04, (32'd3 << 12) | 32'h84);
    repeat (30) @(negedge clk);
    wr(5'h04, (32'd0 << 12) | 32'h81);
    rd(5'h04, d); chk("R12 cmd readback", d, 32'h0000_3084);
    wait_tff("R12");
    chk("R12 data out", mlog, 64'h0DF0_FECA);
    chk("R12 select", 64'(cs_seen), 64'h8);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule